// File: doc/BRIEF.md
# Multiplexed Bus I/O Port Decoder

This block sits between a processor whose low sixteen address bits share lines with its data bus and a small peripheral with four byte-wide registers. While the address-latch-enable strobe is high it captures the shared lines and the I/O-versus-memory qualifier. After the strobe drops it holds both, so the data that later appears on the same lines does not disturb the decode.

The held address is compared with a base value supplied on an input. The comparison works on the difference between the held address and the base, taken modulo 2^16, so a window of four registers may start at any address. The decoder then gives the peripheral an active-low select and a 2-bit register index. A parameter picks how the registers are spread. In byte-wide mapping they sit at consecutive addresses. In 16-bit-bus mapping they sit at alternate even addresses, so that the peripheral uses one byte lane. An example is base 0224h with registers at 0224h, 0226h, 0228h and 022Ah.

A four-state bus-phase machine tracks each transfer. PH_IDLE moves to PH_LATCH when ALE is high. PH_LATCH moves to PH_VALID when ALE falls. PH_VALID moves to PH_ACCESS when a read or write strobe is low. PH_ACCESS returns to PH_IDLE when the strobe is released. ALE being high moves any state to PH_LATCH. The select is driven only in PH_ACCESS, so a stale held address can never select the peripheral.

Top module: `iodec_top`

## Requirements
- R1: While ale_i is high the block captures ad_i and io_m_i on each rising clock edge. After ale_i falls it holds the last captured values, whatever later appears on ad_i.
- R2: While rst_n is low the held address and held qualifier are zero, the phase is PH_IDLE, cs_n_o is 1 and reg_sel_o is 0.
- R3: cs_n_o goes low only if the held io_m_i value is 1 (an I/O cycle). A held 0 (a memory cycle) never selects the peripheral.
- R4: With WIDE_BUS=0, let d = (held address - base_i) mod 2^16. The window hits when d < 4, and then reg_sel_o = d[1:0].
- R5: With WIDE_BUS=1, the window hits when d < 8 and d[0] = 0, and then reg_sel_o = d[2:1]. Odd offsets miss. For base 0224h the addresses 0224h, 0226h, 0228h and 022Ah give indices 0, 1, 2 and 3.
- R6: reg_sel_o shows the index while the held I/O address hits the window, and shows 0 otherwise.
- R7: cs_n_o goes low on the clock edge after a low rd_n_i or wr_n_i is seen in PH_VALID, provided the window hits. It stays low while the strobe is held, and returns high one edge after the strobe is released.
- R8: A read or write strobe in PH_IDLE, after a transfer has finished and before a new ALE, leaves cs_n_o high.
- R9: ALE going high during PH_ACCESS ends the select: cs_n_o is high after the next edge.
- R10: The phase moves between PH_IDLE, PH_LATCH, PH_VALID and PH_ACCESS only as described above. cs_n_o is high in every phase except PH_ACCESS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | AW | Shared address/data lines |
| ale_i | input | 1 | Address latch enable, active high |
| io_m_i | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| base_i | input | AW | Base address of the register window |
| cs_n_o | output | 1 | Peripheral select, active low |
| reg_sel_o | output | REG_W | Peripheral register index |

## Verification
A held address or qualifier that is wrong shows up on reg_sel_o in the cycle after ALE falls, before any strobe arrives. It shows up on cs_n_o one edge after the strobe goes low. A phase machine stuck in PH_ACCESS or PH_VALID shows as a select that outlives its strobe, or that answers a strobe with no new ALE. The bench sees either within one or two clocks. Both mappings run side by side on the same bus traffic, so a mix-up of the offset bits shows as differing indices on the two instances.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LATCH  = 2'd1,
        PH_VALID  = 2'd2,
        PH_ACCESS = 2'd3
    } bus_phase_t;
endpackage

// File: rtl/ad_latch.sv
module ad_latch #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale_i,
    input  logic [AW-1:0] ad_i,
    input  logic          io_i,
    output logic [AW-1:0] addr_o,
    output logic          io_o
);
    // capture address phase, hold through the data phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            io_o   <= 1'b0;
        end else if (ale_i) begin
            addr_o <= ad_i;
            io_o   <= io_i;
        end
    end
endmodule

// File: rtl/io_window.sv
module io_window #(
    parameter int AW       = 16,
    parameter int REG_W    = 2,
    parameter bit WIDE_BUS = 1'b0
) (
    input  logic [AW-1:0]    addr_i,
    input  logic             io_i,
    input  logic [AW-1:0]    base_i,
    output logic             hit_o,
    output logic [REG_W-1:0] reg_o
);
    localparam int STEP = WIDE_BUS ? 1 : 0;
    localparam int SPAN = REG_W + STEP;

    logic [AW-1:0]    diff;
    logic             in_win;
    logic [REG_W-1:0] idx;

    assign diff = addr_i - base_i;

    generate
        if (WIDE_BUS) begin : g_wide
            // alternate even addresses, one byte lane
            assign in_win = (diff[AW-1:SPAN] == '0) && !diff[0];
            assign idx    = diff[SPAN-1:1];
        end else begin : g_byte
            assign in_win = (diff[AW-1:SPAN] == '0);
            assign idx    = diff[REG_W-1:0];
        end
    endgenerate

    assign hit_o = in_win && io_i;
    assign reg_o = hit_o ? idx : '0;
endmodule

// File: rtl/bus_phase_fsm.sv
module bus_phase_fsm
    import iodec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ale_i,
    input  logic       strobe_i,
    output bus_phase_t phase_o,
    output logic       access_o
);
    bus_phase_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ale_i) begin
            state_d = PH_LATCH;
        end else begin
            unique case (state_q)
                PH_IDLE:   state_d = PH_IDLE;
                PH_LATCH:  state_d = PH_VALID;
                PH_VALID:  state_d = strobe_i ? PH_ACCESS : PH_VALID;
                PH_ACCESS: state_d = strobe_i ? PH_ACCESS : PH_IDLE;
                default:   state_d = PH_IDLE;
            endcase
        end
    end

    always_comb begin
        phase_o  = state_q;
        access_o = (state_q == PH_ACCESS);
    end
endmodule

// File: rtl/iodec_top.sv
module iodec_top
    import iodec_pkg::*;
#(
    parameter int AW       = 16,
    parameter int REG_W    = 2,
    parameter bit WIDE_BUS = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ad_i,
    input  logic             ale_i,
    input  logic             io_m_i,
    input  logic             rd_n_i,
    input  logic             wr_n_i,
    input  logic [AW-1:0]    base_i,
    output logic             cs_n_o,
    output logic [REG_W-1:0] reg_sel_o
);
    logic [AW-1:0]    addr_q;
    logic             io_q;
    logic             hit;
    logic             access;
    logic             strobe;
    bus_phase_t       phase;

    assign strobe = !rd_n_i || !wr_n_i;

    ad_latch #(.AW(AW)) u_latch (
        .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .ad_i(ad_i),
        .io_i(io_m_i), .addr_o(addr_q), .io_o(io_q)
    );

    io_window #(.AW(AW), .REG_W(REG_W), .WIDE_BUS(WIDE_BUS)) u_win (
        .addr_i(addr_q), .io_i(io_q), .base_i(base_i),
        .hit_o(hit), .reg_o(reg_sel_o)
    );

    bus_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .strobe_i(strobe),
        .phase_o(phase), .access_o(access)
    );

    assign cs_n_o = !(access && hit);
endmodule

// File: rtl/iodec_chk.sv
module iodec_chk
    import iodec_pkg::*;
#(
    parameter int AW    = 16,
    parameter int REG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ale_i,
    input logic             rd_n_i,
    input logic             wr_n_i,
    input logic             cs_n_o,
    input logic [REG_W-1:0] reg_sel_o,
    input logic [AW-1:0]    addr_q,
    input logic             io_q,
    input bus_phase_t       phase
);
    // R2
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (cs_n_o && reg_sel_o == '0 && addr_q == '0 && phase == PH_IDLE));

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ale_i) |-> $stable(addr_q));

    // R3
    io_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> io_q);

    // R7
    cs_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> $past(!rd_n_i || !wr_n_i));

    // R8
    no_stale_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !ale_i) |=> cs_n_o);

    // R9
    ale_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && ale_i) |=> cs_n_o);

    // R10
    cs_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> phase == PH_ACCESS);
endmodule

bind iodec_top iodec_chk #(.AW(AW), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .rd_n_i(rd_n_i),
    .wr_n_i(wr_n_i), .cs_n_o(cs_n_o), .reg_sel_o(reg_sel_o),
    .addr_q(addr_q), .io_q(io_q), .phase(phase)
);

// File: tb/sim_iodec_top.sv
module sim_iodec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ad = '0;
    logic        ale = 1'b0, io_m = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] base0 = '0, base1 = '0;
    logic        cs0_n, cs1_n;
    logic [1:0]  rs0, rs1;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    iodec_top #(.WIDE_BUS(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .ad_i(ad), .ale_i(ale), .io_m_i(io_m),
        .rd_n_i(rd_n), .wr_n_i(wr_n), .base_i(base0),
        .cs_n_o(cs0_n), .reg_sel_o(rs0));

    iodec_top #(.WIDE_BUS(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .ad_i(ad), .ale_i(ale), .io_m_i(io_m),
        .rd_n_i(rd_n), .wr_n_i(wr_n), .base_i(base1),
        .cs_n_o(cs1_n), .reg_sel_o(rs1));

    // returns {hit, index}
    function automatic logic [2:0] model(input logic [15:0] a, b,
                                         input logic io, input logic wide);
        logic [15:0] d;
        logic        h;
        logic [1:0]  r;
        d = a - b;
        if (wide) begin h = (d < 16'd8) && !d[0]; r = d[2:1]; end
        else      begin h = (d < 16'd4);          r = d[1:0]; end
        h = h && io;
        return {h, h ? r : 2'b00};
    endfunction

    task automatic check(input string req, input logic [15:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // full transfer; all sampling on falling edges
    task automatic xfer(input logic [15:0] a, input logic io, input logic wr,
                        input int hold);
        logic [2:0] e0, e1;
        e0 = model(a, base0, io, 1'b0);
        e1 = model(a, base1, io, 1'b1);
        @(negedge clk);
        ale = 1'b1; ad = a; io_m = io;
        @(negedge clk);
        ale = 1'b0; ad = 16'($urandom); io_m = 1'($urandom);
        @(negedge clk);
        // R1 R6: held index visible before strobe, select still off
        check("R1_R4_R6 idx byte", {14'd0, rs0}, {14'd0, e0[1:0]});
        check("R1_R5_R6 idx wide", {14'd0, rs1}, {14'd0, e1[1:0]});
        check("R7 no cs before strobe", {15'd0, cs0_n & cs1_n}, 16'd1);
        if (wr) wr_n = 1'b0; else rd_n = 1'b0;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check("R3_R4_R7 cs byte", {15'd0, cs0_n}, {15'd0, !e0[2]});
            check("R3_R5_R7 cs wide", {15'd0, cs1_n}, {15'd0, !e1[2]});
        end
        rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        check("R7 cs release", {14'd0, cs0_n, cs1_n}, 16'd3);
    endtask

    initial begin
        void'($urandom(32'h1f3a_5c07));
        repeat (3) @(negedge clk);
        // R2
        check("R2 cs reset", {14'd0, cs0_n, cs1_n}, 16'd3);
        check("R2 idx reset", {12'd0, rs0, rs1}, 16'd0);
        rst_n = 1'b1;

        // directed: alternate-address window at 0224h (R5)
        base0 = 16'h0224; base1 = 16'h0224;
        xfer(16'h0224, 1'b1, 1'b0, 2);
        xfer(16'h0226, 1'b1, 1'b1, 1);
        xfer(16'h0228, 1'b1, 1'b0, 1);
        xfer(16'h022A, 1'b1, 1'b1, 1);
        xfer(16'h0225, 1'b1, 1'b0, 1);
        xfer(16'h022C, 1'b1, 1'b0, 1);
        // R3: memory cycle at a matching address
        xfer(16'h0224, 1'b0, 1'b1, 2);
        // R4 wrap: base near top
        base0 = 16'hFFFE; base1 = 16'hFFFC;
        xfer(16'h0001, 1'b1, 1'b0, 1);
        xfer(16'h0002, 1'b1, 1'b0, 1);

        // R8: strobe with no new ALE after a finished transfer
        base0 = 16'h0400; base1 = 16'h0400;
        xfer(16'h0401, 1'b1, 1'b0, 1);
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk);
        check("R8 stale strobe", {14'd0, cs0_n, cs1_n}, 16'd3);
        @(negedge clk);
        check("R8 stale strobe held", {14'd0, cs0_n, cs1_n}, 16'd3);
        rd_n = 1'b1;

        // R9: ALE during access
        @(negedge clk); ale = 1'b1; ad = 16'h0400; io_m = 1'b1;
        @(negedge clk); ale = 1'b0;
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk);
        check("R9 selected before abort", {14'd0, cs0_n, cs1_n}, 16'd0);
        ale = 1'b1; ad = 16'h0400;
        @(negedge clk);
        check("R9 abort", {14'd0, cs0_n, cs1_n}, 16'd3);
        ale = 1'b0; wr_n = 1'b1;
        // R10: after abort a new ALE is needed; phase passes through VALID
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk);
        check("R10 reselect after latch", {14'd0, cs0_n, cs1_n}, 16'd0);
        rd_n = 1'b1;
        @(negedge clk);

        // random traffic
        for (int i = 0; i < 300; i++) begin
            logic [15:0] b, a;
            b = 16'($urandom);
            base0 = b; base1 = b ^ 16'($urandom_range(0, 3));
            a = ($urandom_range(0, 3) != 0) ? b + 16'($urandom_range(0, 9))
                                            : 16'($urandom);
            xfer(a, 1'($urandom_range(0, 4) != 0), 1'($urandom),
                 $urandom_range(1, 3));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule